// File: doc/BRIEF.md
# Correlating Global-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a short shift register holding the outcomes of the most recent branches, whichever branches they were, across the whole program. To pick a 2-bit saturating counter from an untagged table, it joins that history to a few bits of the branch address. Fetch drives a PC on the lookup port. In the same cycle it gets a taken guess and the history value that produced it. Fetch carries that snapshot down the pipeline with the branch.

When the branch resolves, the back end drives the update port with the branch PC, the real direction, the carried snapshot and a flag that says the guess was wrong. The counter at the index formed from the snapshot moves toward the real direction. The real direction is shifted into the global history. On a wrong guess, the history is rebuilt from the snapshot and the real direction, so younger guesses that were wrong are thrown away.

Top module: `corr_hist_predictor`

## Requirements
- R1: After reset every counter holds 1 (weakly not taken) and the global history is zero. So every lookup returns not taken and `lk_hist` equals 0.
- R2: `lk_taken` is bit 1 of the selected counter. Counter values 2 and 3 give taken, and values 0 and 1 give not taken.
- R3: An update with `up_taken`=1 adds one to the selected counter, and the count stays at 3 once it is there.
- R4: An update with `up_taken`=0 subtracts one from the selected counter, and the count stays at 0 once it is there.
- R5: The table index is {history, PC[5:2]}, with the history in the upper bits. PC bits [1:0] and bits above 5 are ignored, and there is no tag, so PCs that share bits [5:2] share a counter.
- R6: An update with `up_mispred`=0 shifts the global history left by one and puts `up_taken` into bit 0.
- R7: An update with `up_mispred`=1 sets the global history to `up_hist` shifted left by one, with `up_taken` in bit 0.
- R8: An update trains the counter at {`up_hist`, `up_pc`[5:2]}, not at the index formed from the current history.
- R9: A lookup in the same cycle as an update to the same counter returns the counter value from before that update.
- R10: When `up_valid` is 0, the other update inputs are ignored: neither the counters nor the history change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | 32 | PC of the branch being fetched |
| lk_taken | output | 1 | Direction guess for `lk_pc` (1 = taken) |
| lk_hist | output | 2 | History snapshot used for this guess |
| up_valid | input | 1 | A resolved branch is presented |
| up_pc | input | 32 | PC of the resolved branch |
| up_taken | input | 1 | Real direction of the resolved branch |
| up_mispred | input | 1 | The guess for this branch was wrong |
| up_hist | input | 2 | Snapshot returned when the branch was looked up |

## Verification
Lookup and training can fall in the same cycle and hit the same counter. When they do, the guess must show the count from before the edge, and the history must move as R6 or R7 says. The bench makes this happen by driving the same PC and history on both ports in one cycle while the counter sits at the taken/not-taken boundary. It then checks the guess before the edge and the changed guess after it. It also drives updates whose snapshot differs from the live history. This tells apart training at the snapshot index from training at the live index, and a shift from a restore.

// File: rtl/gpred_pkg.sv
package gpred_pkg;
    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_RESET = 2'd1;
    localparam ctr_t CTR_MAX   = 2'd3;
    localparam ctr_t CTR_MIN   = 2'd0;

    function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
        ctr_t nxt;
        nxt = cur;
        if (taken) begin
            if (cur != CTR_MAX) nxt = cur + 2'd1;
        end else begin
            if (cur != CTR_MIN) nxt = cur - 2'd1;
        end
        return nxt;
    endfunction
endpackage

// File: rtl/gpred_index.sv
module gpred_index #(
    parameter int HIST_W = 2,
    parameter int ADDR_W = 4
) (
    input  logic [HIST_W-1:0]        hist,
    input  logic [ADDR_W-1:0]        addr,
    output logic [HIST_W+ADDR_W-1:0] idx
);
    always_comb begin
        idx = {hist, addr};
    end
endmodule

// File: rtl/gpred_history.sv
module gpred_history #(
    parameter int HIST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_valid,
    input  logic              upd_taken,
    input  logic              upd_mispred,
    input  logic [HIST_W-1:0] upd_snap,
    output logic [HIST_W-1:0] hist
);
    typedef struct packed {
        logic [HIST_W-1:0] ghr;
    } hist_state_t;

    hist_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (upd_valid) begin
            if (upd_mispred) begin
                st_d.ghr = HIST_W'({upd_snap, upd_taken});
            end else begin
                st_d.ghr = HIST_W'({st_q.ghr, upd_taken});
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ghr <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hist = st_q.ghr;
endmodule

// File: rtl/gpred_table.sv
module gpred_table
    import gpred_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_t             rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic [DEPTH-1:0][1:0] ctr;
    } tbl_state_t;

    tbl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ctr[wr_idx] = ctr_step(st_q.ctr[wr_idx], wr_taken);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                st_q.ctr[i] <= CTR_RESET;
            end
        end else begin
            st_q <= st_d;
        end
    end

    // read from registered state: a same-cycle write is not visible
    assign rd_ctr = st_q.ctr[rd_idx];
endmodule

// File: rtl/corr_hist_predictor.sv
module corr_hist_predictor
    import gpred_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int HIST_W = 2,
    parameter int ADDR_W = 4,
    parameter int PC_LSB = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   lk_pc,
    output logic              lk_taken,
    output logic [HIST_W-1:0] lk_hist,
    input  logic              up_valid,
    input  logic [PC_W-1:0]   up_pc,
    input  logic              up_taken,
    input  logic              up_mispred,
    input  logic [HIST_W-1:0] up_hist
);
    localparam int IDX_W  = HIST_W + ADDR_W;
    localparam int ADDR_H = PC_LSB + ADDR_W - 1;

    logic [HIST_W-1:0] ghr;
    logic [IDX_W-1:0]  lk_idx, up_idx;
    ctr_t              lk_ctr;

    logic unused_pc_bits;
    assign unused_pc_bits = ^{lk_pc[PC_W-1:ADDR_H+1], lk_pc[PC_LSB-1:0],
                              up_pc[PC_W-1:ADDR_H+1], up_pc[PC_LSB-1:0]};

    gpred_history #(.HIST_W(HIST_W)) u_hist (
        .clk         (clk),
        .rst_n       (rst_n),
        .upd_valid   (up_valid),
        .upd_taken   (up_taken),
        .upd_mispred (up_mispred),
        .upd_snap    (up_hist),
        .hist        (ghr)
    );

    gpred_index #(.HIST_W(HIST_W), .ADDR_W(ADDR_W)) u_lk_index (
        .hist (ghr),
        .addr (lk_pc[ADDR_H:PC_LSB]),
        .idx  (lk_idx)
    );

    gpred_index #(.HIST_W(HIST_W), .ADDR_W(ADDR_W)) u_up_index (
        .hist (up_hist),
        .addr (up_pc[ADDR_H:PC_LSB]),
        .idx  (up_idx)
    );

    gpred_table #(.IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lk_idx),
        .rd_ctr   (lk_ctr),
        .wr_en    (up_valid),
        .wr_idx   (up_idx),
        .wr_taken (up_taken)
    );

    assign lk_taken = lk_ctr[1];
    assign lk_hist  = ghr;
endmodule

// File: rtl/gpred_chk.sv
module gpred_chk #(
    parameter int PC_W   = 32,
    parameter int HIST_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PC_W-1:0]   lk_pc,
    input logic              lk_taken,
    input logic [HIST_W-1:0] lk_hist,
    input logic              up_valid,
    input logic              up_taken,
    input logic              up_mispred,
    input logic [HIST_W-1:0] up_hist
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (lk_hist == '0) && !lk_taken);

    // R6
    hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid && !up_mispred |=>
            lk_hist == HIST_W'({$past(lk_hist), $past(up_taken)}));

    // R7
    hist_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid && up_mispred |=>
            lk_hist == HIST_W'({$past(up_hist), $past(up_taken)}));

    // R10
    idle_hist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |=> $stable(lk_hist));

    // R10
    idle_guess_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid ##1 $stable(lk_pc) |-> $stable(lk_taken));
endmodule

bind corr_hist_predictor gpred_chk #(.PC_W(PC_W), .HIST_W(HIST_W)) u_gpred_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_pc      (lk_pc),
    .lk_taken   (lk_taken),
    .lk_hist    (lk_hist),
    .up_valid   (up_valid),
    .up_taken   (up_taken),
    .up_mispred (up_mispred),
    .up_hist    (up_hist)
);

// File: tb/test_corr_hist_predictor.sv
`timescale 1ns/1ps
module test_corr_hist_predictor;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] lk_pc;
    logic        lk_taken;
    logic [1:0]  lk_hist;
    logic        up_valid;
    logic [31:0] up_pc;
    logic        up_taken;
    logic        up_mispred;
    logic [1:0]  up_hist;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    corr_hist_predictor i_corr_hist_predictor (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
        .lk_hist(lk_hist), .up_valid(up_valid), .up_pc(up_pc),
        .up_taken(up_taken), .up_mispred(up_mispred), .up_hist(up_hist)
    );

    typedef struct packed {
        logic       uv;
        logic [3:0] upc;
        logic       ut;
        logic [1:0] uh;
        logic       um;
        logic [3:0] lpc;
        logic       ax;
        logic       et;
        logic [1:0] eh;
    } vec_t;

    // guesses and history are checked before the edge that applies the update
    localparam vec_t VECS [16] = '{
        '{1'b0, 4'd0, 1'b0, 2'b00, 1'b0, 4'd3, 1'b0, 1'b0, 2'b00},
        '{1'b1, 4'd3, 1'b1, 2'b00, 1'b1, 4'd3, 1'b0, 1'b0, 2'b00},
        '{1'b0, 4'd0, 1'b0, 2'b00, 1'b0, 4'd3, 1'b0, 1'b0, 2'b01},
        '{1'b1, 4'd3, 1'b1, 2'b00, 1'b0, 4'd3, 1'b0, 1'b0, 2'b01},
        '{1'b1, 4'd3, 1'b1, 2'b00, 1'b0, 4'd3, 1'b0, 1'b0, 2'b11},
        '{1'b1, 4'd5, 1'b0, 2'b10, 1'b1, 4'd3, 1'b0, 1'b0, 2'b11},
        '{1'b0, 4'd0, 1'b0, 2'b00, 1'b0, 4'd3, 1'b0, 1'b1, 2'b00},
        '{1'b1, 4'd3, 1'b0, 2'b00, 1'b0, 4'd3, 1'b0, 1'b1, 2'b00},
        '{1'b1, 4'd3, 1'b0, 2'b00, 1'b1, 4'd3, 1'b0, 1'b1, 2'b00},
        '{1'b0, 4'd0, 1'b0, 2'b00, 1'b0, 4'd3, 1'b0, 1'b0, 2'b00},
        '{1'b1, 4'd5, 1'b0, 2'b10, 1'b0, 4'd3, 1'b0, 1'b0, 2'b00},
        '{1'b0, 4'd3, 1'b1, 2'b11, 1'b1, 4'd3, 1'b1, 1'b0, 2'b00},
        '{1'b0, 4'd0, 1'b0, 2'b00, 1'b0, 4'd3, 1'b0, 1'b0, 2'b00},
        '{1'b1, 4'd3, 1'b1, 2'b00, 1'b0, 4'd3, 1'b1, 1'b0, 2'b00},
        '{1'b1, 4'd7, 1'b0, 2'b00, 1'b1, 4'd3, 1'b0, 1'b0, 2'b01},
        '{1'b0, 4'd0, 1'b0, 2'b00, 1'b0, 4'd3, 1'b1, 1'b1, 2'b00}
    };

    function automatic logic [31:0] mk_pc(input logic [3:0] idx, input logic alias_bits);
        return {26'h0, idx, 2'b00} | (alias_bits ? 32'h0000_0143 : 32'h0);
    endfunction

    task automatic check(input string tag, input logic act_t, input logic exp_t,
                         input logic [1:0] act_h, input logic [1:0] exp_h);
        n_checks += 2;
        if (act_t !== exp_t) begin
            n_fails++;
            $display("FAIL %s lk_taken actual=%0b expected=%0b", tag, act_t, exp_t);
        end
        if (act_h !== exp_h) begin
            n_fails++;
            $display("FAIL %s lk_hist actual=%0b expected=%0b", tag, act_h, exp_h);
        end
    endtask

    task automatic drive_upd(input logic v, input logic [3:0] idx, input logic t,
                             input logic [1:0] h, input logic m);
        @(negedge clk);
        up_valid = v; up_pc = mk_pc(idx, 1'b0); up_taken = t;
        up_hist = h; up_mispred = m;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; up_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #500us;
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; lk_pc = '0; up_valid = 1'b0; up_pc = '0;
        up_taken = 1'b0; up_mispred = 1'b0; up_hist = '0;
        do_reset();

        // R1 reset state, R2 R3 R4 R5 R6 R7 R8 R9 R10 through the vector walk
        for (int v = 0; v < 16; v++) begin
            @(negedge clk);
            up_valid   = VECS[v].uv;
            up_pc      = mk_pc(VECS[v].upc, VECS[v].ax);
            up_taken   = VECS[v].ut;
            up_hist    = VECS[v].uh;
            up_mispred = VECS[v].um;
            lk_pc      = mk_pc(VECS[v].lpc, VECS[v].ax);
            #1;
            check($sformatf("vec %0d (R1 R2 R3 R4 R5 R6 R7 R8 R9 R10)", v),
                  lk_taken, VECS[v].et, lk_hist, VECS[v].eh);
        end

        // R1: reset mid-run returns every counter to weakly not taken
        do_reset();
        for (int i = 0; i < 16; i++) begin
            lk_pc = mk_pc(i[3:0], 1'b0);
            #1;
            check($sformatf("R1 reset entry %0d", i), lk_taken, 1'b0, lk_hist, 2'b00);
        end

        // R4: floor at 0, then two taken steps reach 2 (taken)
        drive_upd(1'b1, 4'd5, 1'b0, 2'b10, 1'b1);
        drive_upd(1'b1, 4'd5, 1'b0, 2'b10, 1'b1);
        drive_upd(1'b1, 4'd5, 1'b1, 2'b10, 1'b1);
        drive_upd(1'b1, 4'd5, 1'b1, 2'b10, 1'b1);
        drive_upd(1'b1, 4'd9, 1'b0, 2'b01, 1'b1);
        drive_upd(1'b0, 4'd0, 1'b0, 2'b00, 1'b0);
        lk_pc = mk_pc(4'd5, 1'b0);
        #1;
        check("R4 saturate at zero", lk_taken, 1'b1, lk_hist, 2'b10);

        // R9: same-cycle lookup and update at the boundary 2 -> 1
        drive_upd(1'b1, 4'd5, 1'b0, 2'b10, 1'b0);
        up_pc = mk_pc(4'd5, 1'b0);
        #1;
        check("R9 old value before edge", lk_taken, 1'b1, lk_hist, 2'b10);
        drive_upd(1'b1, 4'd5, 1'b0, 2'b10, 1'b1);
        #1;
        check("R9 new value after edge", lk_taken, 1'b0, lk_hist, 2'b00);
        drive_upd(1'b0, 4'd0, 1'b0, 2'b00, 1'b0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule